// File: doc/BRIEF.md
# Serial Port Host Register Front End

This block is the byte-wide, memory-mapped register face of a 16550-style serial port. A host reaches it through a 3-bit offset with separate read and write strobes. It holds the line format, FIFO mode, interrupt enable and baud divisor registers. It reports line status, and it raises one interrupt line for received data.

Behind the registers sit a transmit queue and a receive queue. Each one trades bytes with the serial shifters through plain valid/ready style ports. A programmable divider produces a single-cycle tick once every 16 × divisor system clocks, which serves as the shifters' oversampling strobe. The shifters themselves are outside this block.

Offsets 0 and 1 are banked. Bit 7 of the line control register selects what they reach. When the bit is set, they reach the two divisor bytes. When it is clear, they reach the data queues and the interrupt enable register.

Top module: `uart_hostregs`

## Requirements
- R1: After reset the line control register, interrupt enable register and divisor read 0, the FIFO mode is off, line status reads 8'h20, and `irq`, `baud_tick` and `tx_valid` are 0.
- R2: Offset 3 is the line control register. All 8 bits are read/write, and `char_len` always equals its bits 1:0 (2'b11 selects 8-bit characters).
- R3: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte.
- R4: While line control bit 7 is 0, offset 1 is the interrupt enable register, which stores bits 3:0 and reads 0 in bits 7:4. Toggling bit 7 never changes the stored divisor.
- R5: While line control bit 7 is 0, a write to offset 0 queues the byte for transmission. Queued bytes appear on `tx_data` with `tx_valid` high in the order they were written, and each is removed on a clock edge where `tx_ready` is 1.
- R6: Line status bit 5 is 1 exactly when the transmit queue is empty. A write to offset 0 while the transmit queue is full is dropped.
- R7: A clock edge with `rx_valid` high stores `rx_data` unless the receive queue is full, in which case the byte is dropped. Line status bit 0 is 1 exactly when the receive queue holds a byte. A read of offset 0 with line control bit 7 at 0 returns the oldest byte and removes it.
- R8: A read of offset 0 with line control bit 7 at 0 while the receive queue is empty returns the byte most recently removed (0 after reset) and changes nothing.
- R9: Offset 2 is the FIFO control register and is write-only. When its bit 0 is 1, each queue holds FIFO_DEPTH bytes. When it is 0, each queue holds one byte.
- R10: `irq` is 1 exactly when interrupt enable bit 0 is 1 and the receive queue is not empty. A read of offset 2 returns 8'h04 while `irq` is 1 and 8'h01 otherwise.
- R11: With a nonzero divisor D, `baud_tick` is a one-cycle pulse. The first pulse comes 16·D clock edges after the edge that wrote a divisor byte, and further pulses follow every 16·D edges.
- R12: While the divisor is 0, `baud_tick` stays 0.
- R13: Offsets 4, 6 and 7 read 0, and writes to offsets 4 through 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; a read of offset 0 may pop the receive queue |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Received-data interrupt |
| char_len | output | 2 | Word length select for the shifters |
| baud_tick | output | 1 | 16x oversampling strobe |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Shifter takes `tx_data` this edge |
| rx_valid | input | 1 | Shifter delivers `rx_data` this edge |
| rx_data | input | 8 | Received byte |

## Verification
On every cycle, the assertions check the following:
- the divider is silent while the divisor is zero;
- each tick lands exactly 16·D edges after the previous tick or divisor write;
- the interrupt never rises without a stored byte and the enable bit;
- writes into a full queue leave the queue count unchanged;
- an empty-queue read leaves the held byte alone;
- the divisor moves only on a divisor write.

The bench scenarios cover what a property cannot show. These are the banking of offsets 0 and 1, the ordering of bytes through both queues, the one-byte capacity when the FIFO mode is off, the exact line status and identification encodings, and the tick phase for a sweep of small divisors.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  typedef enum logic [2:0] {
    OFS_DATA = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_FCTL = 3'd2,
    OFS_LCTL = 3'd3,
    OFS_RES4 = 3'd4,
    OFS_LSTS = 3'd5,
    OFS_RES6 = 3'd6,
    OFS_RES7 = 3'd7
  } reg_ofs_e;

  localparam int BANK_BIT    = 7;
  localparam int STS_DR_BIT  = 0;
  localparam int STS_TXE_BIT = 5;

  // line status byte: data-ready and transmit-empty flags
  function automatic logic [7:0] sts_pack(input logic data_rdy, input logic tx_emp);
    logic [7:0] v;
    v = '0;
    v[STS_DR_BIT]  = data_rdy;
    v[STS_TXE_BIT] = tx_emp;
    return v;
  endfunction

  // interrupt identification stub: 8'h04 receive data pending, 8'h01 none
  function automatic logic [7:0] iid_pack(input logic rx_int);
    return rx_int ? 8'h04 : 8'h01;
  endfunction

  // clocks between two baud ticks for a divisor value
  function automatic int unsigned tick_period(input int unsigned div);
    return div * 16;
  endfunction

endpackage

// File: rtl/ur_fifo.sv
module ur_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_one,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [$clog2(DEPTH):0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cap;
  logic             do_push, do_pop;

  assign cap     = cap_one ? CNT_W'(1) : CNT_W'(DEPTH);
  assign empty   = (count == '0);
  assign full    = (count >= cap);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ur_baud_gen.sv
module ur_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 4;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             idle;

  assign idle = (divisor == '0);
  assign last = {divisor, 4'b0000} - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (restart || idle) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ur_regbank.sv
module ur_regbank
  import uart_reg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  input  logic [7:0]       rx_head,
  input  logic             rx_empty,
  input  logic             tx_empty,
  output logic [1:0]       char_len,
  output logic             fifo_en,
  output logic [DIV_W-1:0] divisor,
  output logic             div_load,
  output logic             tx_push,
  output logic             rx_pop,
  output logic             rd0_req,
  output logic             ier0,
  output logic             irq,
  output logic [7:0]       rd_hold,
  output logic [7:0]       rdata
);
  localparam int HI_W = DIV_W - 8;

  reg_ofs_e        ofs;
  logic [7:0]      lctl;
  logic [3:0]      ien;
  logic [7:0]      div_lo;
  logic [HI_W-1:0] div_hi;
  logic            bank;

  assign ofs      = reg_ofs_e'(addr);
  assign bank     = lctl[BANK_BIT];
  assign char_len = lctl[1:0];
  assign divisor  = {div_hi, div_lo};
  assign ier0     = ien[0];
  assign irq      = ien[0] && !rx_empty;

  assign div_load = wr_en && bank && (ofs == OFS_DATA || ofs == OFS_IEN);
  assign tx_push  = wr_en && !bank && (ofs == OFS_DATA);
  assign rd0_req  = rd_en && !bank && (ofs == OFS_DATA);
  assign rx_pop   = rd0_req && !rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl    <= '0;
      ien     <= '0;
      fifo_en <= 1'b0;
      div_lo  <= '0;
      div_hi  <= '0;
      rd_hold <= '0;
    end else begin
      if (wr_en) begin
        case (ofs)
          OFS_DATA: if (bank) div_lo <= wdata;
          OFS_IEN: begin
            if (bank) div_hi <= wdata[HI_W-1:0];
            else      ien    <= wdata[3:0];
          end
          OFS_FCTL: fifo_en <= wdata[0];
          OFS_LCTL: lctl    <= wdata;
          default: ;
        endcase
      end
      if (rx_pop) rd_hold <= rx_head;
    end
  end

  always_comb begin
    case (ofs)
      OFS_DATA: rdata = bank ? div_lo : (rx_empty ? rd_hold : rx_head);
      OFS_IEN:  rdata = bank ? 8'(div_hi) : {4'b0000, ien};
      OFS_FCTL: rdata = iid_pack(irq);
      OFS_LCTL: rdata = lctl;
      OFS_LSTS: rdata = sts_pack(!rx_empty, tx_empty);
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs #(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic [1:0] char_len,
  output logic       baud_tick,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  // named internal events, observed by the bound checker
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             rx_pop, tx_push, tx_pop, div_load, rd0_req, ier0;
  logic             fifo_en;
  logic [DIV_W-1:0] divisor;
  logic [7:0]       rx_head, rd_hold;

  assign tx_valid = !tx_empty;
  assign tx_pop   = tx_ready && !tx_empty;

  ur_regbank #(.DIV_W(DIV_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rx_head  (rx_head),
    .rx_empty (rx_empty),
    .tx_empty (tx_empty),
    .char_len (char_len),
    .fifo_en  (fifo_en),
    .divisor  (divisor),
    .div_load (div_load),
    .tx_push  (tx_push),
    .rx_pop   (rx_pop),
    .rd0_req  (rd0_req),
    .ier0     (ier0),
    .irq      (irq),
    .rd_hold  (rd_hold),
    .rdata    (rdata)
  );

  ur_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_one (!fifo_en),
    .push    (tx_push),
    .din     (wdata),
    .pop     (tx_ready),
    .dout    (tx_data),
    .count   (tx_cnt),
    .empty   (tx_empty),
    .full    (tx_full)
  );

  ur_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_one (!fifo_en),
    .push    (rx_valid),
    .din     (rx_data),
    .pop     (rx_pop),
    .dout    (rx_head),
    .count   (rx_cnt),
    .empty   (rx_empty),
    .full    (rx_full)
  );

  ur_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .restart (div_load),
    .tick    (baud_tick)
  );
endmodule

// File: rtl/ur_hostregs_chk.sv
module ur_hostregs_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          baud_tick,
  input logic                          irq,
  input logic [DIV_W-1:0]              divisor,
  input logic                          div_load,
  input logic [$clog2(FIFO_DEPTH):0]   rx_cnt,
  input logic                          rx_full,
  input logic                          rx_empty,
  input logic                          rx_valid,
  input logic                          rx_pop,
  input logic [$clog2(FIFO_DEPTH):0]   tx_cnt,
  input logic                          tx_full,
  input logic                          tx_push,
  input logic                          tx_pop,
  input logic                          rd0_req,
  input logic [7:0]                    rd_hold,
  input logic                          ier0
);
  localparam int GAP_W = DIV_W + 5;

  // edges since the last tick or divisor write, saturating
  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= '0;
    else if (div_load)         gap <= '0;
    else if (baud_tick)        gap <= GAP_W'(1);
    else if (gap != '1)        gap <= gap + GAP_W'(1);
  end

  // R12
  idle_divider_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !baud_tick);

  // R11
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> (gap == GAP_W'({divisor, 4'b0000})));

  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rx_pop) |=> (rx_cnt == $past(rx_cnt)));

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_req && rx_empty) |=> $stable(rd_hold));

  // R4
  div_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_load |=> $stable(divisor));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!rx_empty && ier0));
endmodule

bind uart_hostregs ur_hostregs_chk #(.FIFO_DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .irq       (irq),
  .divisor   (divisor),
  .div_load  (div_load),
  .rx_cnt    (rx_cnt),
  .rx_full   (rx_full),
  .rx_empty  (rx_empty),
  .rx_valid  (rx_valid),
  .rx_pop    (rx_pop),
  .tx_cnt    (tx_cnt),
  .tx_full   (tx_full),
  .tx_push   (tx_push),
  .tx_pop    (tx_pop),
  .rd0_req   (rd0_req),
  .rd_hold   (rd_hold),
  .ier0      (ier0)
);

// File: tb/sim_uart_hostregs.sv
module sim_uart_hostregs;
  localparam int DEPTH = 4;
  localparam int DW    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, baud_tick, tx_valid;
  logic [1:0] char_len;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_hostregs #(.FIFO_DEPTH(DEPTH), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .char_len(char_len),
    .baud_tick(baud_tick), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_data = d; rx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take();
    tx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, int'(v), int'(exp));
  endtask

  // program divisor d (high byte first) and measure tick phase
  task automatic tick_test(input int d);
    int first = 0, second = 0, seen = 0;
    int win = (d == 0) ? 100 : 32 * d + 8;
    wr(3'd3, 8'h83);
    wr(3'd1, 8'(d >> 8));
    wr(3'd0, 8'(d & 255));
    for (int n = 1; n <= win; n++) begin
      @(posedge clk); @(negedge clk);
      if (baud_tick) begin
        seen++;
        if (first == 0) first = n;
        else if (second == 0) second = n;
      end
    end
    if (d == 0) begin
      check("R12 no tick with zero divisor", seen, 0);
    end else begin
      check("R11 first tick edge", first, 16 * d);
      check("R11 second tick edge", second, 32 * d);
      check("R11 tick count in window", seen, 2);
    end
    wr(3'd3, 8'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 baud_tick", int'(baud_tick), 0);
    check("R1 tx_valid", int'(tx_valid), 0);
    check("R1 char_len", int'(char_len), 0);
    rd_check("R1 line control", 3'd3, 8'h00);
    rd_check("R1 int enable", 3'd1, 8'h00);
    rd_check("R1 line status", 3'd5, 8'h20);
    rd_check("R1 ident", 3'd2, 8'h01);
    wr(3'd3, 8'h80);
    rd_check("R1 divisor low", 3'd0, 8'h00);
    rd_check("R1 divisor high", 3'd1, 8'h00);
    wr(3'd3, 8'h00);

    // R2 word length sweep and full-width storage
    for (int l = 0; l < 4; l++) begin
      wr(3'd3, 8'(l));
      rd_check("R2 line control readback", 3'd3, 8'(l));
      check("R2 char_len", int'(char_len), l);
    end
    wr(3'd3, 8'h5A);
    rd_check("R2 all bits", 3'd3, 8'h5A);
    check("R2 char_len low bits", int'(char_len), 2);

    // R3 banked divisor access
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h50);
    wr(3'd1, 8'h02);
    rd_check("R3 divisor low", 3'd0, 8'h50);
    rd_check("R3 divisor high", 3'd1, 8'h02);

    // R4 interrupt enable and divisor retention
    wr(3'd3, 8'h03);
    wr(3'd1, 8'hFF);
    rd_check("R4 enable keeps low nibble", 3'd1, 8'h0F);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h83);
    rd_check("R4 divisor low kept", 3'd0, 8'h50);
    rd_check("R4 divisor high kept", 3'd1, 8'h02);
    wr(3'd3, 8'h03);

    // R5 R6 transmit queue, FIFO mode on
    wr(3'd2, 8'h01);
    for (int i = 0; i < 6; i++) wr(3'd0, 8'hA0 + 8'(i));
    rd_check("R6 status with queued tx", 3'd5, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      check("R5 tx_valid", int'(tx_valid), 1);
      check("R5 tx order", int'(tx_data), 'hA0 + i);
      tx_take();
    end
    check("R6 overflow bytes dropped", int'(tx_valid), 0);
    rd_check("R6 status tx empty", 3'd5, 8'h20);

    // R7 receive queue and interrupt
    wr(3'd1, 8'h01);
    for (int i = 0; i < 6; i++) rx_push(8'hC0 + 8'(i));
    rd_check("R7 data ready", 3'd5, 8'h21);
    check("R10 irq with data", int'(irq), 1);
    rd_check("R10 ident pending", 3'd2, 8'h04);
    for (int i = 0; i < DEPTH; i++) rd_check("R7 rx order", 3'd0, 8'hC0 + 8'(i));
    check("R10 irq cleared", int'(irq), 0);
    rd_check("R7 drained status", 3'd5, 8'h20);

    // R8 empty read
    rd_check("R8 empty read last byte", 3'd0, 8'hC3);
    rd_check("R8 empty read again", 3'd0, 8'hC3);
    rd_check("R8 no side effect", 3'd5, 8'h20);

    // R9 single-byte mode
    wr(3'd2, 8'h00);
    for (int i = 0; i < 3; i++) wr(3'd0, 8'hB0 + 8'(i));
    check("R9 tx first byte", int'(tx_data), 'hB0);
    tx_take();
    check("R9 tx holds one", int'(tx_valid), 0);
    for (int i = 0; i < 3; i++) rx_push(8'hD0 + 8'(i));
    rd_check("R9 rx first byte", 3'd0, 8'hD0);
    rd_check("R9 rx holds one", 3'd5, 8'h20);
    wr(3'd2, 8'h01);
    for (int i = 0; i < 3; i++) rx_push(8'hE0 + 8'(i));
    for (int i = 0; i < 3; i++) rd_check("R9 deep mode restored", 3'd0, 8'hE0 + 8'(i));

    // R10 enable gating
    wr(3'd1, 8'h00);
    rx_push(8'h11);
    check("R10 irq masked", int'(irq), 0);
    rd_check("R10 ident masked", 3'd2, 8'h01);
    wr(3'd1, 8'h01);
    check("R10 irq unmasked", int'(irq), 1);
    rd_check("R10 pop", 3'd0, 8'h11);
    check("R10 irq after pop", int'(irq), 0);

    // R13 unused offsets
    rd_check("R13 offset 4", 3'd4, 8'h00);
    rd_check("R13 offset 6", 3'd6, 8'h00);
    rd_check("R13 offset 7", 3'd7, 8'h00);
    for (int a = 4; a < 8; a++) wr(3'(a), 8'hFF);
    rd_check("R13 line control intact", 3'd3, 8'h03);
    rd_check("R13 enable intact", 3'd1, 8'h01);
    rd_check("R13 status intact", 3'd5, 8'h20);

    // R11 R12 divider sweep
    for (int d = 0; d <= 4; d++) tick_test(d);
    tick_test(0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule